// File: doc/BRIEF.md
# Serial Flash Page-to-Buffer Copy Sequencer

This block is the host side of a serial-flash command that copies one whole flash page into one of two on-chip SRAM page buffers inside the memory. A single start strobe, together with a buffer select bit and a page number, launches the sequence. The block then drives chip select, serial clock and data-out in SPI mode 0 to issue the copy command, and follows it with status reads until the memory reports that it is ready.

The copy is self-timed inside the memory, so no serial clock is needed while it runs. The sequencer watches one status bit: 0 means the copy is still running and 1 means it has finished. Each status read is a separate chip-select frame. A cycle counter, sized from the system clock frequency and a 400 µs worst case, bounds the wait. If the memory never reports ready within that window, the sequencer stops with an error flag instead of a done pulse.

Top module: `flash_xfer_seq`

## Requirements
- R1: The first byte of the command frame is 0x53 when `buf_sel` is 0 and 0x55 when `buf_sel` is 1.
- R2: Three address bytes follow the command byte, most significant byte first and each byte MSB first. The 24-bit address equals `page_addr` shifted left by OFF_W bits, so the in-page offset bits are sent as zero.
- R3: The command is one chip-select-low frame of exactly 32 serial clocks. Chip select rises only after the last address bit, and that rise starts the copy.
- R4: SPI mode 0 is used. The serial clock stays low whenever chip select is high. MOSI changes only while the clock is low, and MISO is sampled on rising clock edges.
- R5: After the command, the block polls status. Each poll is its own chip-select-low frame of 16 clocks: the STATUS_OP byte goes out, then one status byte is read MSB first. Chip select is high between frames.
- R6: Only bit 7 of the status byte decides completion. While bit 7 reads 0, polling continues whatever the other seven bits hold.
- R7: When a poll returns bit 7 = 1, `done` is high for exactly one clock and `busy` drops in that same clock.
- R8: If bit 7 has not been seen high after TMO_CYC = (CLK_HZ/1e6)·XFER_MAX_US clocks from the end of the command, checked between polls, the block stops. It sets `xfer_err`, issues no `done`, and drops `busy`. `xfer_err` stays high until the next accepted start.
- R9: A start strobe that arrives while `busy` is high is ignored. No second command frame is produced, and the frame in progress is unaffected.
- R10: After reset, chip select is high, the serial clock is low, and `busy`, `done` and `xfer_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, accepted only when idle |
| buf_sel | input | 1 | Target buffer: 0 first, 1 second |
| page_addr | input | PAGE_W | Flash page number |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the copy has finished |
| xfer_err | output | 1 | Timeout seen; held until next accepted start |
| spi_csb | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest case to reach from the ports is the timeout path. It needs a memory that keeps answering "busy" across many poll frames, while its other status bits are set so that a wrong bit decode would end the wait early. The bench's flash model can hold the ready bit low forever and returns 0x7F in every busy poll. The bench instance shortens the worst-case window to a few microseconds, so expiry falls within reach. The bench then measures the cycles from the command's chip-select rise to the error flag and checks them against the window plus one poll frame.

// File: rtl/flash_xfer_pkg.sv
package flash_xfer_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_CMD,
    SEQ_GAP,
    SEQ_POLL
  } seq_state_t;

  localparam logic [7:0] OP_COPY_BUF0 = 8'h53;
  localparam logic [7:0] OP_COPY_BUF1 = 8'h55;

  // Command byte for the selected destination buffer.
  function automatic logic [7:0] copy_opcode(input logic sel);
    return sel ? OP_COPY_BUF1 : OP_COPY_BUF0;
  endfunction

  // Page number placed above the in-page byte offset, offset bits zero.
  function automatic logic [23:0] page_to_addr(input logic [23:0] page,
                                               input int unsigned off_w);
    return page << off_w;
  endfunction

  // Worst-case copy time expressed in system clock cycles.
  function automatic int unsigned timeout_cycles(input int unsigned clk_hz,
                                                 input int unsigned max_us);
    return (clk_hz / 1_000_000) * max_us;
  endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] tx_byte,
  input  logic       tick,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic       active
);
  logic [7:0] sh_out;
  logic [7:0] sh_in;
  logic [3:0] half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_out    <= '0;
      sh_in     <= '0;
      half      <= '0;
      sclk      <= 1'b0;
      active    <= 1'b0;
      byte_done <= 1'b0;
    end else if (load) begin
      sh_out    <= tx_byte;
      half      <= '0;
      sclk      <= 1'b0;
      active    <= 1'b1;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (active && tick) begin
        if (!half[0]) begin
          sclk  <= 1'b1;                    // rising edge: sample
          sh_in <= {sh_in[6:0], miso};
        end else begin
          sclk   <= 1'b0;                   // falling edge: next bit out
          sh_out <= {sh_out[6:0], 1'b0};
          if (half == 4'd15) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end
        end
        half <= half + 1'b1;
      end
    end
  end

  assign mosi    = sh_out[7];
  assign rx_byte = sh_in;
endmodule

// File: rtl/flash_xfer_seq.sv
module flash_xfer_seq
  import flash_xfer_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 250_000_000,
  parameter int unsigned SPI_DIV     = 4,
  parameter int unsigned XFER_MAX_US = 400,
  parameter int unsigned PAGE_W      = 13,
  parameter int unsigned OFF_W       = 9,
  parameter logic [7:0]  STATUS_OP   = 8'hD7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              buf_sel,
  input  logic [PAGE_W-1:0] page_addr,
  output logic              busy,
  output logic              done,
  output logic              xfer_err,
  output logic              spi_csb,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int unsigned TMO_CYC = timeout_cycles(CLK_HZ, XFER_MAX_US);
  localparam int unsigned TMO_W   = $clog2(TMO_CYC + 1);
  localparam int unsigned GAP_CYC = 2 * SPI_DIV;
  localparam int unsigned GAP_W   = $clog2(GAP_CYC + 1);

  seq_state_t       state;
  logic [31:0]      cmd_word;
  logic [1:0]       idx;
  logic [7:0]       tx_q;
  logic             load_q;
  logic [GAP_W-1:0] gap_cnt;
  logic [TMO_W-1:0] tmo_cnt;

  logic       tick, eng_active, byte_done;
  logic [7:0] rx_byte;

  // Named internal events, also used by the checker.
  logic cmd_sent, poll_ready, tmo_expired, gap_over;
  assign cmd_sent    = (state == SEQ_CMD)  && byte_done && (idx == 2'd3);
  assign poll_ready  = (state == SEQ_POLL) && byte_done && (idx == 2'd1) && rx_byte[7];
  assign tmo_expired = (tmo_cnt >= TMO_W'(TMO_CYC));
  assign gap_over    = (gap_cnt == GAP_W'(GAP_CYC - 1));

  spi_tick_gen #(.DIV(SPI_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (eng_active),
    .tick (tick)
  );

  spi_byte_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_q),
    .tx_byte  (tx_q),
    .tick     (tick),
    .miso     (spi_miso),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .rx_byte  (rx_byte),
    .byte_done(byte_done),
    .active   (eng_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      cmd_word <= '0;
      idx      <= '0;
      tx_q     <= '0;
      load_q   <= 1'b0;
      gap_cnt  <= '0;
      tmo_cnt  <= '0;
      done     <= 1'b0;
      xfer_err <= 1'b0;
      spi_csb  <= 1'b1;
    end else begin
      load_q <= 1'b0;
      done   <= 1'b0;
      if ((state == SEQ_GAP || state == SEQ_POLL) && !tmo_expired)
        tmo_cnt <= tmo_cnt + 1'b1;
      unique case (state)
        SEQ_IDLE: if (start) begin
          cmd_word <= {copy_opcode(buf_sel), page_to_addr(24'(page_addr), OFF_W)};
          tx_q     <= copy_opcode(buf_sel);
          load_q   <= 1'b1;
          idx      <= '0;
          xfer_err <= 1'b0;
          spi_csb  <= 1'b0;
          state    <= SEQ_CMD;
        end
        SEQ_CMD: if (byte_done) begin
          if (idx == 2'd3) begin
            spi_csb <= 1'b1;
            gap_cnt <= '0;
            tmo_cnt <= '0;
            state   <= SEQ_GAP;
          end else begin
            tx_q   <= cmd_word[(23 - 8 * int'(idx)) -: 8];
            load_q <= 1'b1;
            idx    <= idx + 1'b1;
          end
        end
        SEQ_GAP: begin
          if (gap_over) begin
            if (tmo_expired) begin
              xfer_err <= 1'b1;
              state    <= SEQ_IDLE;
            end else begin
              spi_csb <= 1'b0;
              tx_q    <= STATUS_OP;
              load_q  <= 1'b1;
              idx     <= '0;
              state   <= SEQ_POLL;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        SEQ_POLL: if (byte_done) begin
          if (idx == 2'd0) begin
            tx_q   <= 8'h00;
            load_q <= 1'b1;
            idx    <= 2'd1;
          end else begin
            spi_csb <= 1'b1;
            gap_cnt <= '0;
            if (rx_byte[7]) begin
              done  <= 1'b1;
              state <= SEQ_IDLE;
            end else begin
              state <= SEQ_GAP;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy = (state != SEQ_IDLE);
endmodule

// File: rtl/flash_xfer_sva.sv
module flash_xfer_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        xfer_err,
  input logic        spi_csb,
  input logic        spi_sclk,
  input logic        spi_mosi,
  input logic        cmd_sent,
  input logic        poll_ready,
  input logic [31:0] cmd_word
);
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csb |-> !spi_sclk);

  assert_mosi_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));

  assert_csb_after_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sent |=> spi_csb);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ready |=> (done && !busy));

  assert_end_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || xfer_err));

  assert_no_done_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_err);

  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(cmd_word));
endmodule

bind flash_xfer_seq flash_xfer_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .xfer_err  (xfer_err),
  .spi_csb   (spi_csb),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .cmd_sent  (cmd_sent),
  .poll_ready(poll_ready),
  .cmd_word  (cmd_word)
);

// File: tb/tb_flash_xfer_seq.sv
`timescale 1ns/1ps
module tb_flash_xfer_seq;
  localparam int unsigned PAGE_W = 13;
  localparam int unsigned OFF_W  = 9;
  localparam logic [7:0]  SOP    = 8'hD7;
  localparam int          TMO    = 250 * 4;   // 4 us at 250 MHz

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic buf_sel = 1'b0;
  logic [PAGE_W-1:0] page_addr = '0;
  logic busy, done, xfer_err, spi_csb, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;

  always #2 clk = ~clk;

  flash_xfer_seq #(
    .CLK_HZ(250_000_000), .SPI_DIV(2), .XFER_MAX_US(4),
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .STATUS_OP(SOP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .buf_sel(buf_sel),
    .page_addr(page_addr), .busy(busy), .done(done), .xfer_err(xfer_err),
    .spi_csb(spi_csb), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ---------------- flash model and scoreboard monitor ----------------
  logic [31:0] exp_q[$];
  logic [7:0]  frame[$];
  logic [7:0]  cur = '0;
  logic [7:0]  status_now = 8'h80;
  int rx_bits = 0;
  int polls_left = 0;
  int busy_polls_cfg = 0;
  bit never_ready = 0;
  int poll_count = 0;
  int cmd_frames = 0;
  int cmd_end_cyc = 0;

  always @(negedge spi_csb) begin
    frame.delete();
    rx_bits = 0;
    status_now = (never_ready || polls_left > 0) ? 8'h7F : 8'h80;
  end

  always @(posedge spi_sclk) if (!spi_csb) begin
    cur = {cur[6:0], spi_mosi};
    rx_bits++;
    if (rx_bits % 8 == 0) frame.push_back(cur);
  end

  always @(negedge spi_sclk) if (!spi_csb) begin
    if (rx_bits >= 8 && rx_bits <= 15 && frame.size() > 0 && frame[0] == SOP)
      spi_miso = status_now[15 - rx_bits];
    else
      spi_miso = 1'b0;
  end

  always @(posedge spi_csb) if (rx_bits > 0) begin
    check(spi_sclk == 1'b0, "R4 clock idle low at frame end", spi_sclk, 0);
    if (frame.size() > 0 && frame[0] == SOP) begin
      poll_count++;
      check(rx_bits == 16, "R5 poll frame length", rx_bits, 16);
      if (polls_left > 0) polls_left--;
    end else begin
      logic [31:0] e;
      cmd_frames++;
      cmd_end_cyc = cyc;
      polls_left = busy_polls_cfg;
      check(rx_bits == 32, "R3 command frame clocks", rx_bits, 32);
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected command frame", cmd_frames, 0);
      end else if (frame.size() == 4) begin
        e = exp_q.pop_front();
        check(frame[0] == e[31:24], "R1 opcode", frame[0], e[31:24]);
        check({frame[1], frame[2], frame[3]} == e[23:0], "R2 address bytes",
              {frame[1], frame[2], frame[3]}, e[23:0]);
      end
    end
    rx_bits = 0;
  end

  // ---------------- driver ----------------
  task automatic pulse_start(input logic sel, input logic [PAGE_W-1:0] pg);
    @(negedge clk);
    start = 1'b1; buf_sel = sel; page_addr = pg;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_xfer(input logic sel, input logic [PAGE_W-1:0] pg, input int bpolls);
    int n = 0;
    busy_polls_cfg = bpolls;
    never_ready = 0;
    poll_count = 0;
    exp_q.push_back({(sel ? 8'h55 : 8'h53), 24'(pg) * 24'd512});
    pulse_start(sel, pg);
    check(busy == 1'b1, "R7 busy after start", busy, 1);
    while (!done && !xfer_err && n < 20000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R7 done seen", done, 1);
    check(busy == 1'b0, "R7 busy low with done", busy, 0);
    check(xfer_err == 1'b0, "R8 no error on success", xfer_err, 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    check(poll_count == bpolls + 1, "R6 poll count", poll_count, bpolls + 1);
    check(exp_q.size() == 0, "R1 command frame consumed", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int frames_before;
    int n;
    bit saw_done;
    repeat (5) @(negedge clk);
    // R10 reset state
    check(spi_csb == 1'b1, "R10 csb high", spi_csb, 1);
    check(spi_sclk == 1'b0, "R10 sclk low", spi_sclk, 0);
    check(busy == 1'b0, "R10 busy low", busy, 0);
    check(done == 1'b0, "R10 done low", done, 0);
    check(xfer_err == 1'b0, "R10 err low", xfer_err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_xfer(1'b0, 13'h0001, 0);   // R1 buffer 0, ready at first poll
    run_xfer(1'b1, 13'h1ABC, 2);   // R1 buffer 1, R6 busy polls read 0x7F
    run_xfer(1'b0, 13'h1FFF, 4);   // R2 top page, all page bits set

    // R9: start during busy is ignored
    frames_before = cmd_frames;
    busy_polls_cfg = 3; never_ready = 0; poll_count = 0;
    exp_q.push_back({8'h55, 24'(13'h0123) * 24'd512});
    pulse_start(1'b1, 13'h0123);
    repeat (40) @(negedge clk);
    pulse_start(1'b0, 13'h0777);
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    repeat (400) @(negedge clk);
    check(cmd_frames == frames_before + 1, "R9 single command frame",
          cmd_frames - frames_before, 1);
    check(poll_count == 4, "R9 polls unaffected", poll_count, 4);

    // R8: never ready -> timeout error
    never_ready = 1; busy_polls_cfg = 0; poll_count = 0; saw_done = 0;
    exp_q.push_back({8'h53, 24'(13'h0042) * 24'd512});
    pulse_start(1'b0, 13'h0042);
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk); n++;
      if (done) saw_done = 1;
    end
    check(xfer_err == 1'b1, "R8 error raised", xfer_err, 1);
    check(!saw_done, "R8 no done on timeout", saw_done, 0);
    check((cyc - cmd_end_cyc) >= TMO, "R8 not before window", cyc - cmd_end_cyc, TMO);
    check((cyc - cmd_end_cyc) <= TMO + 120, "R8 not long after window",
          cyc - cmd_end_cyc, TMO + 120);
    check(poll_count > 3, "R6 kept polling while bit7 low", poll_count, 4);
    repeat (50) @(negedge clk);
    check(xfer_err == 1'b1, "R8 error held", xfer_err, 1);

    // R8: next accepted start clears the error
    never_ready = 0;
    run_xfer(1'b1, 13'h0800, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule